// File: doc/BRIEF.md
# Queue Occupancy and Latency Monitor

This block sits beside a request-tracking queue and watches only two numbers per cycle: how many entries the queue allocated and how many it released. From these it keeps its own live count of valid entries and four statistics. Two of them count cycles: the cycles in which every entry was in use and the cycles in which at least one entry was in use. The third adds the live entry count into an accumulator every cycle. The fourth counts the entries that were accepted into the queue.

Software reads the statistics through a small select-and-read port. It gets average residency latency by dividing the occupancy total by the allocation count; the block does not divide. A synchronous clear restarts a measurement window and leaves the live count alone, so the monitor stays aligned with a queue that is still in use. Several allocations and releases may arrive in the same cycle. Requests that would drive the count below zero or above the depth are clipped, and they raise a sticky error.

Top module: `qocc_monitor`

## Requirements
- R1: After reset, the live count, the error flag and all four statistics are zero.
- R2: Each cycle the block accepts the releases first and then the allocations. It accepts min(dealloc_n, count) releases, where count is the pre-update live count. It then accepts min(alloc_n, DEPTH - (count - accepted releases)) allocations. The live count becomes count minus the accepted releases plus the accepted allocations.
- R3: In a cycle where some releases or allocations are not accepted, err_flag is set on the next edge. The surplus has no other effect. err_flag stays set until a clear or a reset.
- R4: The full-cycles statistic grows by one in every cycle where the pre-update live count equals DEPTH.
- R5: The non-empty statistic grows by one in every cycle where the pre-update live count is nonzero.
- R6: The occupancy statistic grows by the pre-update live count every cycle.
- R7: The allocation statistic grows by the number of allocations accepted that cycle.
- R8: A cycle with clr high zeroes all four statistics and err_flag on the next edge. That cycle's own events are dropped from the statistics, and the live count still updates as in R2.
- R9: Each statistic saturates at 2^STAT_W-1 and holds that value until a clear or a reset.
- R10: rd_data shows, in the same cycle, the statistic chosen by rd_sel: 0 full cycles, 1 non-empty cycles, 2 occupancy, 3 allocations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous statistics clear |
| alloc_n | input | CW | Entries allocated this cycle |
| dealloc_n | input | CW | Entries released this cycle |
| rd_sel | input | 2 | Statistic select |
| rd_data | output | STAT_W | Selected statistic |
| live_count | output | CW | Tracked number of valid entries |
| err_flag | output | 1 | Sticky over/underflow flag |

CW is $clog2(DEPTH+1).

## Verification
The embedded properties check the following on every cycle. The live count never exceeds the depth and holds steady when no strobe is active. The error flag stays set until a clear. A counter only grows between clears, drops to zero after a clear and holds at its ceiling once saturated. The exact increments need the bench's reference model, compared every clock: occupancy taken from the pre-update count, clipping of surplus strobes, and dropping a clear cycle's own events. The same applies to ceiling arrival under a long run of full cycles and to the read-select mapping.

// File: rtl/qocc_pkg.sv
package qocc_pkg;

    typedef enum logic [1:0] {
        SEL_FULL   = 2'd0,
        SEL_NEMPTY = 2'd1,
        SEL_OCC    = 2'd2,
        SEL_ALLOC  = 2'd3
    } stat_sel_e;

    localparam int unsigned NUM_STATS = 4;

endpackage

// File: rtl/qocc_tracker.sv
module qocc_tracker #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [CW-1:0] alloc_n,
    input  logic [CW-1:0] dealloc_n,
    output logic [CW-1:0] count,
    output logic [CW-1:0] alloc_ok,
    output logic          err
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic [CW-1:0] rel_ok, held, space;
    logic          bad;

    always_comb begin
        rel_ok   = (dealloc_n > count) ? count : dealloc_n;
        held     = count - rel_ok;
        space    = DEPTH_C - held;
        alloc_ok = (alloc_n > space) ? space : alloc_n;
        bad      = (rel_ok != dealloc_n) || (alloc_ok != alloc_n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            err   <= 1'b0;
        end else begin
            count <= held + alloc_ok;
            err   <= clr ? 1'b0 : (err | bad);
        end
    end

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= DEPTH_C);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (alloc_n == '0 && dealloc_n == '0) |=> $stable(count));

    // R3
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err && !clr) |=> err);

    // R3
    drain_chk: assert property (@(posedge clk) disable iff (rst)
        (alloc_n == '0 && dealloc_n >= count) |=> (count == '0));

endmodule

// File: rtl/qocc_stat_ctr.sv
module qocc_stat_ctr #(
    parameter int unsigned W  = 32,
    parameter int unsigned IW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [IW-1:0] inc,
    output logic [W-1:0]  acc
);
    localparam int unsigned SW = W + 1;

    logic [SW-1:0] sum;

    always_comb sum = {1'b0, acc} + SW'(inc);

    always_ff @(posedge clk) begin
        if (rst || clr)  acc <= '0;
        else if (sum[W]) acc <= '1;
        else             acc <= sum[W-1:0];
    end

    // R8
    clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc == '0));

    // R9
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (acc == '1 && !clr) |=> (acc == '1));

    // R6
    no_shrink_chk: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (acc >= $past(acc)));

endmodule

// File: rtl/qocc_monitor.sv
module qocc_monitor #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned STAT_W = 32,
    parameter int unsigned CW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic [CW-1:0]     alloc_n,
    input  logic [CW-1:0]     dealloc_n,
    input  logic [1:0]        rd_sel,
    output logic [STAT_W-1:0] rd_data,
    output logic [CW-1:0]     live_count,
    output logic              err_flag
);
    import qocc_pkg::*;

    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic [CW-1:0]     count, alloc_ok;
    logic [CW-1:0]     inc  [NUM_STATS];
    logic [STAT_W-1:0] stat [NUM_STATS];
    stat_sel_e         sel;

    qocc_tracker #(.DEPTH(DEPTH), .CW(CW)) u_trk (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .alloc_n   (alloc_n),
        .dealloc_n (dealloc_n),
        .count     (count),
        .alloc_ok  (alloc_ok),
        .err       (err_flag)
    );

    always_comb begin
        inc[SEL_FULL]   = CW'(count == DEPTH_C);
        inc[SEL_NEMPTY] = CW'(count != '0);
        inc[SEL_OCC]    = count;
        inc[SEL_ALLOC]  = alloc_ok;
    end

    for (genvar i = 0; i < NUM_STATS; i++) begin : g_stat
        qocc_stat_ctr #(.W(STAT_W), .IW(CW)) u_ctr (
            .clk (clk),
            .rst (rst),
            .clr (clr),
            .inc (inc[i]),
            .acc (stat[i])
        );
    end

    always_comb begin
        sel     = stat_sel_e'(rd_sel);
        rd_data = stat[sel];
    end

    assign live_count = count;

    // R4
    full_step_chk: assert property (@(posedge clk) disable iff (rst)
        (count == DEPTH_C && !clr && stat[SEL_FULL] != '1)
        |=> (stat[SEL_FULL] == $past(stat[SEL_FULL]) + 1'b1));

    // R5
    empty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && !clr) |=> $stable(stat[SEL_NEMPTY]));

endmodule

// File: tb/qocc_monitor_test.sv
`timescale 1ns/1ps
module qocc_monitor_test;
    localparam int DEPTH  = 4;
    localparam int STAT_W = 8;
    localparam int CW     = $clog2(DEPTH + 1);
    localparam int SMAX   = (1 << STAT_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              clr = 1'b0;
    logic [CW-1:0]     alloc_n = '0;
    logic [CW-1:0]     dealloc_n = '0;
    logic [1:0]        rd_sel = '0;
    logic [STAT_W-1:0] rd_data;
    logic [CW-1:0]     live_count;
    logic              err_flag;

    int ntests = 0;
    int nfail  = 0;
    bit done   = 0;

    int m_cnt = 0;
    int m_err = 0;
    int m_stat [4] = '{0, 0, 0, 0};

    always #4 clk = ~clk;

    qocc_monitor #(.DEPTH(DEPTH), .STAT_W(STAT_W)) uut (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .alloc_n    (alloc_n),
        .dealloc_n  (dealloc_n),
        .rd_sel     (rd_sel),
        .rd_data    (rd_data),
        .live_count (live_count),
        .err_flag   (err_flag)
    );

    function automatic int sat(int x);
        return (x > SMAX) ? SMAX : x;
    endfunction

    task automatic check(int act, int exp, string ctx, string what);
        ntests++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s / %s: actual %0d expected %0d", ctx, what, act, exp);
        end
    endtask

    task automatic model_update(int a, int d, bit c);
        int pre = m_cnt;
        int de = (d < m_cnt) ? d : m_cnt;
        int space = DEPTH - (m_cnt - de);
        int ae = (a < space) ? a : space;
        bit er = (de < d) || (ae < a);
        if (c) begin
            for (int i = 0; i < 4; i++) m_stat[i] = 0;
            m_err = 0;
        end else begin
            m_stat[0] = sat(m_stat[0] + ((pre == DEPTH) ? 1 : 0));
            m_stat[1] = sat(m_stat[1] + ((pre != 0) ? 1 : 0));
            m_stat[2] = sat(m_stat[2] + pre);
            m_stat[3] = sat(m_stat[3] + ae);
            if (er) m_err = 1;
        end
        m_cnt = m_cnt - de + ae;
    endtask

    task automatic compare_all(string ctx);
        check(int'(live_count), m_cnt, ctx, "R2 live count");
        check(int'(err_flag), m_err, ctx, "R3 error flag");
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s);
            #0.2;
            case (s)
                0: check(int'(rd_data), m_stat[0], ctx, "R4 full cycles via R10 sel 0");
                1: check(int'(rd_data), m_stat[1], ctx, "R5 non-empty cycles via R10 sel 1");
                2: check(int'(rd_data), m_stat[2], ctx, "R6 occupancy via R10 sel 2");
                default: check(int'(rd_data), m_stat[3], ctx, "R7 allocations via R10 sel 3");
            endcase
        end
    endtask

    task automatic step(int a, int d, bit c, string ctx);
        alloc_n   = CW'(a);
        dealloc_n = CW'(d);
        clr       = c;
        @(posedge clk);
        model_update(a, d, c);
        @(negedge clk);
        alloc_n   = '0;
        dealloc_n = '0;
        clr       = 1'b0;
        compare_all(ctx);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        compare_all("R1 reset state");

        step(2, 0, 0, "R2 allocate two");
        step(3, 0, 0, "R3 over-allocate");
        step(0, 0, 0, "R4 full idle");
        step(1, 1, 0, "R2 swap at full");
        step(0, 6, 0, "R3 over-release");
        step(0, 1, 0, "R3 release when empty");
        step(1, 0, 1, "R8 clear with allocate");
        step(0, 0, 0, "R8 after clear");
        step(4, 0, 0, "R2 fill");
        for (int i = 0; i < 300; i++) step(0, 0, 0, "R9 saturation run");
        step(2, 2, 0, "R9 held at ceiling");
        step(0, 0, 1, "R8 clear after saturation");
        for (int i = 0; i < 3000; i++) begin
            int a = ($urandom_range(0, 9) == 0) ? $urandom_range(0, 7) : $urandom_range(0, 2);
            int d = ($urandom_range(0, 9) == 0) ? $urandom_range(0, 7) : $urandom_range(0, 2);
            bit c = ($urandom_range(0, 59) == 0);
            step(a, d, c, "R2 random traffic");
        end

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule